// File: doc/BRIEF.md
# Burst Read WAIT Generator

This block sequences synchronous burst reads on the device side of a flash bus that shares address and data lines. A rising clock edge that sees the address-valid strobe low, chip enable active and synchronous mode selected captures a start address. The block then counts a configured latency and presents one data word per clock from a computed internal array. It also drives a WAIT line that tells the host whether the word on the bus in a given cycle is usable.

The configuration register value arrives on an input port. At the capturing edge the block latches the latency, the burst addressing mode and the WAIT timing. WAIT polarity follows the live input, so the idle level is correct even between bursts. In continuous (no-wrap) bursts, moving from the last word of a 512-word row to the first word of the next row inserts a parameterised number of stall clocks, and WAIT flags them. In wrap mode the address cycles inside an aligned 16-word group and never stalls. The register value whose fields all hold their reset defaults is 0x1910: asynchronous mode, 3-clock latency, early WAIT, WAIT high meaning valid, half drive strength and wrap mode.

Top module: `burst_wait_seq`

## Requirements
- R1: While no burst is active, including after a synchronous active-high reset, dq_o is 0 and wait_o sits at the data-valid level.
- R2: With cfg_i bit 15 at 0 (asynchronous mode) a low adv_n starts nothing and the outputs stay idle. With bit 15 at 1 a rising edge that sees adv_n low and ce_n low captures addr_i and starts a burst.
- R3: cfg_i bits 13:11 give the latency L in clocks. The first word appears on dq_o in the cycle that follows the L-th rising edge after the capturing edge, and all earlier cycles of the burst carry no valid data.
- R4: Latency codes 0 and 1 behave as 2, and code 7 behaves as 6.
- R5: After the first word, each clock presents the next address. The word at address a is (a*0x9E37 + 0x1234) mod 65536. dq_o is 0 in every cycle without valid data.
- R6: With cfg_i bit 3 at 0 (wrap), only the low 4 address bits advance, wrapping within an aligned 16-word group, and no stall cycles occur.
- R7: With cfg_i bit 3 at 1 (no-wrap), the word at row offset 511 is followed by STALL_CYCLES (default 2) cycles without valid data, and then by the word at the next address (row offset 0 of the next row).
- R8: With cfg_i bit 8 at 1, wait_o in each cycle reports the validity of the next cycle's data. With bit 8 at 0, it reports the validity of the current cycle's data.
- R9: With cfg_i bit 10 at 0, wait_o high means valid and low means not valid. With bit 10 at 1 the levels are swapped.
- R10: A rising edge that sees ce_n high ends any burst, and the following cycle is idle as in R1.
- R11: cfg_i bits 5:4 (the drive-strength field) have no effect on dq_o or wait_o.
- R12: A new capture during a running burst restarts the sequence from the new address and latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv_n | input | 1 | Address-valid strobe, active low |
| ce_n | input | 1 | Chip enable, active low; high aborts a burst |
| addr_i | input | ADDR_W | Start word address sampled at capture |
| cfg_i | input | 16 | Configuration register value |
| dq_o | output | 16 | Data word, 0 when not valid |
| wait_o | output | 1 | Data-valid indication, timing and level set by cfg_i |

## Verification
The assertions assume that cfg_i stays constant from a capturing edge until the burst ends or restarts, because polarity is read live while the other fields are latched. They also assume that inputs never change at a rising edge. The bench writes cfg_i, adv_n, ce_n and addr_i only on falling edges, changes cfg_i only in the same cycle as a new capture or while idle, and keeps ce_n low for the whole of every burst it compares. Abort and asynchronous-mode checks drive ce_n and bit 15 on their own, with the reference model expecting an idle bus.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

    localparam int CFG_W   = 16;
    localparam int DQ_W    = 16;
    localparam int LAT_W   = 3;

    localparam logic [LAT_W-1:0] LAT_MIN = 3'd2;
    localparam logic [LAT_W-1:0] LAT_MAX = 3'd6;

    // field positions inside the configuration word
    localparam int BIT_SYNC   = 15;
    localparam int LAT_HI     = 13;
    localparam int LAT_LO     = 11;
    localparam int BIT_ACTLOW = 10;
    localparam int BIT_EARLY  = 8;
    localparam int BIT_NOWRAP = 3;

    typedef struct packed {
        logic             sync_mode;
        logic             nowrap;
        logic             wait_early;
        logic             wait_act_low;
        logic [LAT_W-1:0] lat_clks;
    } burst_cfg_t;

    function automatic logic [LAT_W-1:0] clamp_lat(input logic [LAT_W-1:0] code);
        if (code < LAT_MIN) return LAT_MIN;
        if (code > LAT_MAX) return LAT_MAX;
        return code;
    endfunction

    // contents of the internal read-only array, derived from the address
    function automatic logic [DQ_W-1:0] word_at(input logic [15:0] a);
        logic [15:0] p;
        p = a * 16'h9E37;
        return p + 16'h1234;
    endfunction

endpackage

// File: rtl/bwg_cfg_decode.sv
module bwg_cfg_decode
    import bwg_pkg::*;
(
    input  logic [CFG_W-1:0] raw,
    output burst_cfg_t       dec
);
    // drive strength, and the bits with no function here, are left alone
    logic field_unused;
    assign field_unused = ^{raw[14], raw[9], raw[7:4], raw[2:0]};

    always_comb begin
        dec.sync_mode    = raw[BIT_SYNC];
        dec.nowrap       = raw[BIT_NOWRAP];
        dec.wait_early   = raw[BIT_EARLY];
        dec.wait_act_low = raw[BIT_ACTLOW];
        dec.lat_clks     = clamp_lat(raw[LAT_HI:LAT_LO]);
    end
endmodule

// File: rtl/bwg_seq_ctrl.sv
module bwg_seq_ctrl
    import bwg_pkg::*;
#(
    parameter int STALL_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic [LAT_W-1:0] lat_load,
    input  logic             nowrap,
    input  logic             row_last,
    output logic             busy,
    output logic             dvalid,
    output logic             dvalid_next
);
    localparam int STALL_W = $clog2(STALL_CYCLES + 1);

    logic             busy_q;
    logic [LAT_W-1:0] lat_q;
    logic [STALL_W-1:0] stall_q;
    logic             crossing;

    assign crossing = nowrap && row_last;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy_q  <= 1'b0;
            lat_q   <= '0;
            stall_q <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            lat_q   <= lat_load;
            stall_q <= '0;
        end else if (busy_q) begin
            if (lat_q != '0)
                lat_q <= lat_q - 1'b1;
            else if (stall_q != '0)
                stall_q <= stall_q - 1'b1;
            else if (crossing)
                stall_q <= STALL_W'(STALL_CYCLES);
        end
    end

    assign busy   = busy_q;
    assign dvalid = busy_q && (lat_q == '0) && (stall_q == '0);

    always_comb begin
        if (!busy_q)
            dvalid_next = 1'b0;
        else if (lat_q != '0)
            dvalid_next = (lat_q == LAT_W'(1));
        else if (stall_q != '0)
            dvalid_next = (stall_q == STALL_W'(1));
        else
            dvalid_next = !crossing;
    end
endmodule

// File: rtl/bwg_addr_gen.sv
module bwg_addr_gen #(
    parameter int ADDR_W     = 16,
    parameter int ROW_WORDS  = 512,
    parameter int WRAP_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    input  logic              nowrap,
    output logic [ADDR_W-1:0] addr_q,
    output logic              row_last
);
    localparam int ROW_LG  = $clog2(ROW_WORDS);
    localparam int WRAP_LG = $clog2(WRAP_WORDS);

    logic [ADDR_W-1:0] addr_inc;

    always_comb begin
        if (nowrap)
            addr_inc = addr_q + 1'b1;
        else
            addr_inc = {addr_q[ADDR_W-1:WRAP_LG], addr_q[WRAP_LG-1:0] + 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (load)
            addr_q <= load_addr;
        else if (advance)
            addr_q <= addr_inc;
    end

    assign row_last = (addr_q[ROW_LG-1:0] == '1);
endmodule

// File: rtl/bwg_out_stage.sv
module bwg_out_stage
    import bwg_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              busy,
    input  logic              dvalid,
    input  logic              dvalid_next,
    input  logic              early,
    input  logic              act_low,
    input  logic [ADDR_W-1:0] addr_q,
    output logic [DQ_W-1:0]   dq_o,
    output logic              wait_o
);
    logic not_ready;

    assign not_ready = busy && !(early ? dvalid_next : dvalid);
    // act_low=0: high means valid; act_low=1: low means valid
    assign wait_o    = not_ready ? act_low : !act_low;
    assign dq_o      = dvalid ? word_at(16'(addr_q)) : '0;
endmodule

// File: rtl/burst_wait_seq.sv
module burst_wait_seq
    import bwg_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int ROW_WORDS    = 512,
    parameter int WRAP_WORDS   = 16,
    parameter int STALL_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CFG_W-1:0]  cfg_i,
    output logic [DQ_W-1:0]   dq_o,
    output logic              wait_o
);
    burst_cfg_t        cfg_live;
    burst_cfg_t        cfg_q;
    logic              start;
    logic              busy;
    logic              dvalid;
    logic              dvalid_next;
    logic              row_last;
    logic [ADDR_W-1:0] addr_q;
    logic              cfg_unused;

    bwg_cfg_decode u_dec (
        .raw (cfg_i),
        .dec (cfg_live)
    );

    assign start = !adv_n && !ce_n && cfg_live.sync_mode;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (start)
            cfg_q <= cfg_live;
    end

    assign cfg_unused = ^{cfg_q.sync_mode, cfg_q.wait_act_low, cfg_q.lat_clks,
                          cfg_live.nowrap, cfg_live.wait_early};

    bwg_seq_ctrl #(
        .STALL_CYCLES (STALL_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .abort       (ce_n),
        .lat_load    (cfg_live.lat_clks),
        .nowrap      (cfg_q.nowrap),
        .row_last    (row_last),
        .busy        (busy),
        .dvalid      (dvalid),
        .dvalid_next (dvalid_next)
    );

    bwg_addr_gen #(
        .ADDR_W     (ADDR_W),
        .ROW_WORDS  (ROW_WORDS),
        .WRAP_WORDS (WRAP_WORDS)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .load_addr (addr_i),
        .advance   (dvalid),
        .nowrap    (cfg_q.nowrap),
        .addr_q    (addr_q),
        .row_last  (row_last)
    );

    bwg_out_stage #(
        .ADDR_W (ADDR_W)
    ) u_out (
        .busy        (busy),
        .dvalid      (dvalid),
        .dvalid_next (dvalid_next),
        .early       (cfg_q.wait_early),
        .act_low     (cfg_live.wait_act_low),
        .addr_q      (addr_q),
        .dq_o        (dq_o),
        .wait_o      (wait_o)
    );
endmodule

// File: rtl/bwg_checker.sv
module bwg_checker
    import bwg_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int ROW_WORDS = 512
) (
    input logic              clk,
    input logic              rst,
    input logic              adv_n,
    input logic              ce_n,
    input logic [CFG_W-1:0]  cfg_i,
    input logic [DQ_W-1:0]   dq_o,
    input logic              wait_o,
    input logic              busy,
    input logic              dvalid,
    input burst_cfg_t        cfg_q,
    input logic [ADDR_W-1:0] addr_q
);
    localparam int ROW_LG = $clog2(ROW_WORDS);

    logic cap;
    logic at_row_end;
    logic hold;

    assign cap        = !adv_n && !ce_n && cfg_i[BIT_SYNC];
    assign at_row_end = (addr_q[ROW_LG-1:0] == '1);
    assign hold       = !cap && !ce_n;

    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dq_o == '0 && wait_o == !cfg_i[BIT_ACTLOW]));

    assert_async_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cfg_i[BIT_SYNC]) |=> !busy);

    assert_latency_start_R3: assert property (@(posedge clk) disable iff (rst)
        cap |=> (busy && !dvalid));

    assert_next_addr_R5: assert property (@(posedge clk) disable iff (rst)
        (dvalid && hold && cfg_q.nowrap && !at_row_end) |=>
            (dvalid && addr_q == $past(addr_q) + 1'b1));

    assert_wrap_no_stall_R6: assert property (@(posedge clk) disable iff (rst)
        (dvalid && hold && !cfg_q.nowrap) |=> dvalid);

    assert_row_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (dvalid && hold && cfg_q.nowrap && at_row_end) |=> (busy && !dvalid));

    assert_early_wait_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && hold && cfg_q.wait_early) |=>
            (dvalid == $past(wait_o == !cfg_i[BIT_ACTLOW])));

    assert_abort_R10: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> !busy);
endmodule

bind burst_wait_seq bwg_checker #(
    .ADDR_W    (ADDR_W),
    .ROW_WORDS (ROW_WORDS)
) i_bwg_checker (
    .clk    (clk),
    .rst    (rst),
    .adv_n  (adv_n),
    .ce_n   (ce_n),
    .cfg_i  (cfg_i),
    .dq_o   (dq_o),
    .wait_o (wait_o),
    .busy   (busy),
    .dvalid (dvalid),
    .cfg_q  (cfg_q),
    .addr_q (addr_q)
);

// File: tb/test_burst_wait_seq.sv
module test_burst_wait_seq;
    localparam int CLK_PERIOD = 10;
    localparam int STALLS     = 2;

    logic        clk;
    logic        rst;
    logic        adv_n;
    logic        ce_n;
    logic [15:0] addr_i;
    logic [15:0] cfg_i;
    logic [15:0] dq_o;
    logic        wait_o;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    burst_wait_seq i_burst_wait_seq (
        .clk    (clk),
        .rst    (rst),
        .adv_n  (adv_n),
        .ce_n   (ce_n),
        .addr_i (addr_i),
        .cfg_i  (cfg_i),
        .dq_o   (dq_o),
        .wait_o (wait_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int word_of(input int a);
        longint p;
        p = (longint'(a) * 40503 + 4660) & 65535;
        return int'(p);
    endfunction

    function automatic logic [15:0] mk_cfg(input int sync, input int lat, input int early,
                                            input int actlow, input int nowrap, input int drv);
        int v;
        v = (sync << 15) | (lat << 11) | (actlow << 10) | (early << 8) | (drv << 4) | (nowrap << 3);
        return 16'(v);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // idle bus: dq 0, wait at valid level (R1)
    task automatic idle_run(input logic [15:0] cfg, input logic adv, input logic ce,
                            input int ncyc, input string req);
        cfg_i = cfg;
        adv_n = adv;
        ce_n  = ce;
        for (int n = 0; n < ncyc; n++) begin
            @(negedge clk);
            chk({req, " dq"}, int'(dq_o), 0);
            chk({req, " wait"}, int'(wait_o), cfg[10] ? 0 : 1);
        end
    endtask

    // starts a burst at the next falling edge and compares ncyc cycles
    task automatic burst(input int start, input logic [15:0] cfg, input int ncyc, input string req);
        int vq[$];
        int aq[$];
        int lat;
        int a;
        int exp_nr;
        lat = int'(cfg[13:11]);
        if (lat < 2) lat = 2;
        if (lat > 6) lat = 6;
        for (int i = 0; i < lat; i++) begin
            vq.push_back(0);
            aq.push_back(0);
        end
        a = start;
        while (vq.size() < ncyc + 2) begin
            vq.push_back(1);
            aq.push_back(a);
            if (cfg[3]) begin
                if ((a % 512) == 511) begin
                    for (int s = 0; s < STALLS; s++) begin
                        vq.push_back(0);
                        aq.push_back(0);
                    end
                end
                a = (a + 1) & 65535;
            end else begin
                a = (a & ~15) | ((a + 1) & 15);
            end
        end
        @(negedge clk);
        adv_n  = 1'b0;
        ce_n   = 1'b0;
        addr_i = 16'(start);
        cfg_i  = cfg;
        for (int n = 0; n < ncyc; n++) begin
            @(negedge clk);
            if (n == 0) adv_n = 1'b1;
            chk({req, " dq"}, int'(dq_o), vq[n] ? word_of(aq[n]) : 0);
            exp_nr = cfg[8] ? !vq[n+1] : !vq[n];
            chk({req, " wait"}, int'(wait_o), exp_nr ? int'(cfg[10]) : int'(!cfg[10]));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst    = 1'b1;
        adv_n  = 1'b1;
        ce_n   = 1'b1;
        addr_i = '0;
        cfg_i  = 16'h1910;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        idle_run(16'h1910, 1'b1, 1'b1, 3, "R1 reset");
        // R2 asynchronous mode ignores the strobe
        idle_run(16'h1910, 1'b0, 1'b0, 5, "R2 async");
        idle_run(16'h1910, 1'b1, 1'b1, 1, "R2 async release");

        // R7 R8 R9 every WAIT timing and polarity across the row boundary
        for (int e = 0; e < 2; e++) begin
            for (int p = 0; p < 2; p++) begin
                burst(509, mk_cfg(1, 3, e, p, 1, 1), 14, "R7 R8 R9 row cross");
                idle_run(mk_cfg(1, 3, e, p, 1, 1), 1'b1, 1'b1, 2, "R10 R9 after cross");
            end
        end

        // R3 latency settings, R5 data sequence
        burst(100, mk_cfg(1, 2, 1, 0, 1, 1), 10, "R3 lat2");
        burst(200, mk_cfg(1, 4, 0, 0, 1, 1), 10, "R3 lat4");
        burst(300, mk_cfg(1, 6, 1, 1, 1, 1), 12, "R3 lat6");
        // R4 clamped codes
        burst(40, mk_cfg(1, 0, 0, 0, 1, 1), 8, "R4 code0");
        burst(41, mk_cfg(1, 1, 1, 0, 1, 1), 8, "R4 code1");
        burst(42, mk_cfg(1, 7, 0, 1, 1, 1), 12, "R4 code7");
        // R6 wrap mode, including the row end
        burst(509, mk_cfg(1, 3, 1, 0, 0, 1), 14, "R6 wrap row end");
        burst(14, mk_cfg(1, 2, 0, 1, 0, 1), 10, "R6 wrap low");
        // R11 drive strength codes
        burst(1021, mk_cfg(1, 3, 0, 0, 1, 0), 10, "R11 drive0");
        burst(1021, mk_cfg(1, 3, 0, 0, 1, 3), 10, "R11 drive3");
        burst(1021, mk_cfg(1, 3, 0, 0, 1, 2), 10, "R11 drive2");
        // R5 crossing a higher row with long latency
        burst(2045, mk_cfg(1, 5, 1, 1, 1, 1), 14, "R5 R7 row 3");
        // R10 abort mid-burst
        burst(500, mk_cfg(1, 2, 1, 0, 1, 1), 5, "R10 before abort");
        idle_run(mk_cfg(1, 2, 1, 0, 1, 1), 1'b1, 1'b1, 3, "R10 abort");
        // R12 restart during a burst
        burst(60, mk_cfg(1, 2, 0, 0, 1, 1), 6, "R12 first");
        burst(700, mk_cfg(1, 4, 1, 1, 0, 1), 10, "R12 restart");
        idle_run(mk_cfg(1, 4, 1, 1, 0, 1), 1'b1, 1'b1, 2, "R1 end idle");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule